// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status and Mask Unit

This block gathers the event pulses of an Ethernet controller into one interrupt line. Six sources each own one bit of a status register: a PHY link change, transmit completion, receive error, receive overflow, receive drop, and a receive coalescing timer. A pulse sets its bit, and the bit stays set until software clears it. A mask register chooses which status bits drive the interrupt output. The PHY change bit drives the output whatever its mask bit holds.

Software uses a 32-bit register bus with a write strobe and an address. Read data is combinational from the address. Status bits are cleared by writing 1 to them. A built-in receive coalescing timer turns a burst of received frames into one notification. Each frame pulse reloads a down-counter. When the counter runs out while frames are pending, the timer bit is set. An optional frame-count threshold raises the timer bit early.

Top module: `eth_irq_unit`

## Requirements
- R1: After reset, the status, mask and timer control registers read zero, and irq_o is low.
- R2: A one-cycle event pulse sets its status bit at the next clock edge. The bit positions are: PHY change 24, transmit done 16, receive error 8, receive overflow 7, receive drop 6, receive timer 5.
- R3: Writing to the status register (offset 0x104) clears every bit written as 1. Bits written as 0 keep their value.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: irq_o is a register. One edge after (status & mask) becomes nonzero, or status bit 24 becomes set, irq_o is high. The mask register is at offset 0x100. Writing zero to the mask drops irq_o one edge later, unless status bit 24 is set.
- R6: Status bit 24 asserts irq_o even when mask bit 24 is zero.
- R7: Status and mask bits other than 24, 16, 8, 7, 6 and 5 always read zero, and writes to them have no effect. Reads from unmapped offsets return zero.
- R8: The timer control register is at offset 0x34C. Bit 27 enables the timer, bits 23:16 hold the frame threshold, and bits 15:0 hold the interval. These fields read back, and all other bits read zero.
- R9: With the timer enabled, each receive frame pulse reloads the counter with the interval. Status bit 5 is set at the edge interval+1 edges after the last frame pulse, provided no further frame arrives.
- R10: With a nonzero threshold, the frame pulse that brings the pending count to the threshold sets status bit 5 at that same edge.
- R11: With the timer disabled, frame pulses never set status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| ev_phy_i | input | 1 | PHY change pulse |
| ev_tx_done_i | input | 1 | Transmit completion pulse |
| ev_rx_err_i | input | 1 | Receive error pulse |
| ev_rx_ovf_i | input | 1 | Receive overflow pulse |
| ev_rx_drop_i | input | 1 | Receive drop pulse |
| rx_frame_i | input | 1 | Received frame pulse for the timer |
| irq_o | output | 1 | Interrupt request |

## Verification
Random patterns mix event pulses, clearing writes with random data, mask writes and writes to unmapped offsets. A bench model tracks the status, mask and registered interrupt on every cycle, which exposes lost events, wrong clear bits and wrong interrupt latency. Directed cases cover the following:
- an event colliding with its own clear, which separates "event wins" from "clear wins";
- the PHY bit under a zero mask, which tests the mask bypass;
- a single frame against the exact expiry edge, which exposes off-by-one counting;
- a second frame during the countdown, which proves the reload;
- two back-to-back frames against a threshold of two, which tests the early path;
- frames with the timer disabled.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NUM_SRC = 6;

  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_TMR  = 12'h34C;

  localparam int BIT_TMR  = 5;
  localparam int BIT_DROP = 6;
  localparam int BIT_OVF  = 7;
  localparam int BIT_ERR  = 8;
  localparam int BIT_TX   = 16;
  localparam int BIT_PHY  = 24;

  localparam int TMR_EN_BIT = 27;
  localparam int THR_LSB    = 16;

  localparam logic [DATA_W-1:0] STAT_VALID =
    (32'd1 << BIT_TMR) | (32'd1 << BIT_DROP) | (32'd1 << BIT_OVF) |
    (32'd1 << BIT_ERR) | (32'd1 << BIT_TX)   | (32'd1 << BIT_PHY);

  // source index -> status bit position
  function automatic int src_bit(input int idx);
    case (idx)
      0:       return BIT_TMR;
      1:       return BIT_DROP;
      2:       return BIT_OVF;
      3:       return BIT_ERR;
      4:       return BIT_TX;
      default: return BIT_PHY;
    endcase
  endfunction
endpackage

// File: rtl/eth_irq_status.sv
module eth_irq_status
  import eth_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= 1'b0;
      else if (set_i[g])  q <= 1'b1;   // new event beats clear
      else if (clr_i[g])  q <= 1'b0;
    end
    assign pend_o[g] = q;
  end
endmodule

// File: rtl/eth_irq_regs.sv
module eth_irq_regs
  import eth_irq_pkg::*;
#(
  parameter int IV_W = 16,
  parameter int TH_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic              tmr_en_o,
  output logic [IV_W-1:0]   tmr_ival_o,
  output logic [TH_W-1:0]   tmr_thr_o
);
  logic [DATA_W-1:0] mask_q;
  logic              en_q;
  logic [IV_W-1:0]   ival_q;
  logic [TH_W-1:0]   thr_q;
  logic              wr_mask, wr_stat, wr_tmr;

  assign wr_mask = wen_i && (addr_i == OFS_MASK);
  assign wr_stat = wen_i && (addr_i == OFS_STAT);
  assign wr_tmr  = wen_i && (addr_i == OFS_TMR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= 1'b0;
      ival_q <= '0;
      thr_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata_i & STAT_VALID;
      if (wr_tmr) begin
        en_q   <= wdata_i[TMR_EN_BIT];
        ival_q <= wdata_i[IV_W-1:0];
        thr_q  <= wdata_i[THR_LSB +: TH_W];
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
    localparam int B = src_bit(g);
    assign clr_o[g] = wr_stat && wdata_i[B];
  end

  logic [DATA_W-1:0] tmr_word;
  always_comb begin
    tmr_word = '0;
    tmr_word[TMR_EN_BIT]        = en_q;
    tmr_word[IV_W-1:0]          = ival_q;
    tmr_word[THR_LSB +: TH_W]   = thr_q;
  end

  always_comb begin
    case (addr_i)
      OFS_MASK: rdata_o = mask_q;
      OFS_STAT: rdata_o = stat_i;
      OFS_TMR:  rdata_o = tmr_word;
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o     = mask_q;
  assign tmr_en_o   = en_q;
  assign tmr_ival_o = ival_q;
  assign tmr_thr_o  = thr_q;
endmodule

// File: rtl/eth_irq_rx_timer.sv
module eth_irq_rx_timer #(
  parameter int IV_W = 16,
  parameter int TH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [IV_W-1:0] ival_i,
  input  logic [TH_W-1:0] thr_i,
  input  logic            frame_i,
  output logic            fire_o
);
  logic [IV_W-1:0] cnt_q;
  logic [TH_W-1:0] pend_q, pend_nx;
  logic            expire, thr_hit;

  // saturating count of frames since last notification
  assign pend_nx = (frame_i && pend_q != '1) ? pend_q + 1'b1 : pend_q;
  assign expire  = (pend_q != '0) && (cnt_q == '0) && !frame_i;
  assign thr_hit = (thr_i != '0) && (pend_nx >= thr_i);
  assign fire_o  = en_i && (expire || thr_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (!en_i || fire_o) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (frame_i) begin
      cnt_q  <= ival_i;
      pend_q <= pend_nx;
    end else if (pend_q != '0 && cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/eth_irq_unit.sv
module eth_irq_unit
  import eth_irq_pkg::*;
#(
  parameter int IV_W = 16,
  parameter int TH_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wen_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ev_phy_i,
  input  logic              ev_tx_done_i,
  input  logic              ev_rx_err_i,
  input  logic              ev_rx_ovf_i,
  input  logic              ev_rx_drop_i,
  input  logic              rx_frame_i,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] set_v, clr_v, pend_v;
  logic [DATA_W-1:0]  stat_q, mask_q;
  logic               tmr_en, tmr_fire;
  logic [IV_W-1:0]    tmr_ival;
  logic [TH_W-1:0]    tmr_thr;
  logic               irq_q;

  assign set_v = {ev_phy_i, ev_tx_done_i, ev_rx_err_i,
                  ev_rx_ovf_i, ev_rx_drop_i, tmr_fire};

  eth_irq_regs #(.IV_W(IV_W), .TH_W(TH_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wen_i      (reg_wen_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .stat_i     (stat_q),
    .rdata_o    (reg_rdata_o),
    .mask_o     (mask_q),
    .clr_o      (clr_v),
    .tmr_en_o   (tmr_en),
    .tmr_ival_o (tmr_ival),
    .tmr_thr_o  (tmr_thr)
  );

  eth_irq_rx_timer #(.IV_W(IV_W), .TH_W(TH_W)) i_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tmr_en),
    .ival_i  (tmr_ival),
    .thr_i   (tmr_thr),
    .frame_i (rx_frame_i),
    .fire_o  (tmr_fire)
  );

  eth_irq_status #(.N(NUM_SRC)) i_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .pend_o (pend_v)
  );

  always_comb begin
    stat_q = '0;
    for (int i = 0; i < NUM_SRC; i++) stat_q[src_bit(i)] = pend_v[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|(stat_q & mask_q)) | stat_q[BIT_PHY];
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/eth_irq_chk.sv
module eth_irq_chk
  import eth_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wen_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              ev_phy_i,
  input logic              ev_tx_done_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              tmr_en
);
  p_event_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_tx_done_i || ev_phy_i) |=> (stat_q[BIT_TX] || stat_q[BIT_PHY]));

  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wen_i && reg_addr_i == OFS_STAT && reg_wdata_i[BIT_TX] && !ev_tx_done_i)
      |=> !stat_q[BIT_TX]);

  p_collide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wen_i && reg_addr_i == OFS_STAT && reg_wdata_i[BIT_TX] && ev_tx_done_i)
      |=> stat_q[BIT_TX]);

  p_irq_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(((stat_q & mask_q) != '0) || stat_q[BIT_PHY]));

  p_phy_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[BIT_PHY] |=> irq_o);

  p_rsvd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q | mask_q) & ~STAT_VALID) == '0);

  p_tmr_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_en |=> !$rose(stat_q[BIT_TMR]));
endmodule

bind eth_irq_unit eth_irq_chk i_chk (.*);

// File: tb/test_eth_irq_unit.sv
module test_eth_irq_unit;
  import eth_irq_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wen_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        ev_phy_i = 1'b0, ev_tx_done_i = 1'b0, ev_rx_err_i = 1'b0;
  logic        ev_rx_ovf_i = 1'b0, ev_rx_drop_i = 1'b0, rx_frame_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  eth_irq_unit i_eth_irq_unit (.*);

  // bench model (timer left disabled while compared)
  logic [31:0] m_stat, m_mask;
  logic        m_irq;

  function automatic logic [31:0] ev_word();
    return ({31'd0, ev_phy_i} << 24) | ({31'd0, ev_tx_done_i} << 16) |
           ({31'd0, ev_rx_err_i} << 8) | ({31'd0, ev_rx_ovf_i} << 7) |
           ({31'd0, ev_rx_drop_i} << 6);
  endfunction

  function automatic logic [31:0] next_stat(logic [31:0] s, logic [31:0] ev,
                                            logic wen, logic [11:0] a, logic [31:0] d);
    logic [31:0] clr = (wen && a == 12'h104) ? d : 32'd0;
    return ((s & ~clr) | ev) & 32'h010101E0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stat <= '0; m_mask <= '0; m_irq <= 1'b0;
    end else begin
      m_irq  <= (|(m_stat & m_mask)) | m_stat[24];
      m_stat <= next_stat(m_stat, ev_word(), reg_wen_i, reg_addr_i, reg_wdata_i);
      if (reg_wen_i && reg_addr_i == 12'h100) m_mask <= reg_wdata_i & 32'h010101E0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wen_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step(1);
    reg_wen_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr_i = a; #0.1; d = reg_rdata_o;
  endtask

  task automatic frame();
    rx_frame_i = 1'b1; step(1); rx_frame_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    @(negedge clk_i); @(negedge clk_i);
    rd(12'h104, d); chk("R1 status", d, 0);
    rd(12'h100, d); chk("R1 mask", d, 0);
    rd(12'h34C, d); chk("R1 tmr", d, 0);
    chk("R1 irq", irq_o, 0);
    rst_ni = 1'b1;
    step(1);

    // random mix against model (R2 R3 R5 R7)
    for (int it = 0; it < 3000; it++) begin
      reg_wen_i = 0; reg_addr_i = 12'h104;
      ev_phy_i = 0; ev_tx_done_i = 0; ev_rx_err_i = 0; ev_rx_ovf_i = 0; ev_rx_drop_i = 0;
      #0.1;
      chk("R2/R3 status model", reg_rdata_o, m_stat);
      chk("R5 irq model", irq_o, m_irq);
      ev_phy_i     = ($urandom % 16) == 0;
      ev_tx_done_i = ($urandom % 4) == 0;
      ev_rx_err_i  = ($urandom % 4) == 0;
      ev_rx_ovf_i  = ($urandom % 4) == 0;
      ev_rx_drop_i = ($urandom % 4) == 0;
      rx_frame_i   = ($urandom % 4) == 0;
      if (($urandom % 3) == 0) begin
        int k = $urandom % 3;
        reg_wen_i = 1;
        reg_addr_i = (k == 0) ? 12'h104 : (k == 1) ? 12'h100 : 12'h108;
        reg_wdata_i = $urandom;
      end
      @(posedge clk_i); @(negedge clk_i);
    end
    reg_wen_i = 0; rx_frame_i = 0;
    ev_phy_i = 0; ev_tx_done_i = 0; ev_rx_err_i = 0; ev_rx_ovf_i = 0; ev_rx_drop_i = 0;

    // R7 reserved bits
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, d); chk("R7 mask reserved", d, 32'h0101_01E0);
    wr(12'h104, 32'hFFFF_FFFF);
    rd(12'h104, d); chk("R3 clear all", d, 0);
    rd(12'h200, d); chk("R7 unmapped", d, 0);

    // R4 collision
    ev_tx_done_i = 1; reg_wen_i = 1; reg_addr_i = 12'h104; reg_wdata_i = 32'h0001_0000;
    step(1);
    ev_tx_done_i = 0; reg_wen_i = 0;
    rd(12'h104, d); chk("R4 event wins", d, 32'h0001_0000);
    wr(12'h104, 32'h0000_0100);
    rd(12'h104, d); chk("R3 zero bits kept", d, 32'h0001_0000);
    wr(12'h104, 32'h0001_0000);

    // R6 PHY bypass, R5 latency
    wr(12'h100, 0);
    step(2);
    chk("R5 irq low", irq_o, 0);
    ev_phy_i = 1; step(1); ev_phy_i = 0;
    rd(12'h104, d); chk("R2 phy bit", d, 32'h0100_0000);
    chk("R5 irq one edge later", irq_o, 0);
    step(1);
    chk("R6 phy unmasked irq", irq_o, 1);
    wr(12'h104, 32'h0100_0000);
    step(1);
    chk("R3 phy clear irq", irq_o, 0);

    // R5 mask to zero drops irq
    wr(12'h100, 32'h0001_0000);
    ev_tx_done_i = 1; step(1); ev_tx_done_i = 0;
    step(1);
    chk("R5 masked tx irq", irq_o, 1);
    wr(12'h100, 0);
    step(1);
    chk("R5 mask zero drops", irq_o, 0);
    wr(12'h104, 32'hFFFF_FFFF);

    // R8 timer control readback
    wr(12'h34C, 32'hFFFF_FFFF);
    rd(12'h34C, d); chk("R8 tmr fields", d, 32'h08FF_FFFF);

    // R9 interval expiry edge
    wr(12'h34C, 32'h0800_0005);
    frame();
    step(5);
    rd(12'h104, d); chk("R9 before expiry", d & 32'h20, 0);
    step(1);
    rd(12'h104, d); chk("R9 at expiry", d & 32'h20, 32'h20);
    wr(12'h100, 32'h20);
    step(1);
    chk("R5 timer irq", irq_o, 1);
    wr(12'h100, 0);
    wr(12'h104, 32'h20);

    // R9 reload
    frame();
    step(3);
    frame();
    step(5);
    rd(12'h104, d); chk("R9 reload holds", d & 32'h20, 0);
    step(1);
    rd(12'h104, d); chk("R9 reload expiry", d & 32'h20, 32'h20);
    wr(12'h104, 32'h20);

    // R10 threshold 2, interval 100
    wr(12'h34C, 32'h0802_0064);
    frame();
    rd(12'h104, d); chk("R10 below thr", d & 32'h20, 0);
    frame();
    rd(12'h104, d); chk("R10 thr hit", d & 32'h20, 32'h20);
    wr(12'h104, 32'h20);

    // R11 disabled
    wr(12'h34C, 32'h0000_0002);
    frame(); frame();
    step(10);
    rd(12'h104, d); chk("R11 disabled", d & 32'h20, 0);

    finish_run();
  end
endmodule